// File: doc/BRIEF.md
# Hash Accelerator Register Front End

This block is the bus-facing control and status shell of a hash engine that supports MD5, SHA-1, SHA-224 and SHA-256. It decodes a 32-bit register bus and holds four things: a soft reset, the message length in bits, and the algorithm and byte-order selection. It also holds a set of sticky interrupt flags with an enable mask and a write-one-to-clear register. The hash core sits behind it. The core receives a configuration bundle and a one-cycle start pulse when the control word is written.

When the core finishes, it pushes its digest words through a valid/ready handshake into a result store. Software drains that store by repeatedly reading one register. The store is last-in first-out, so the final digest word comes out first. A driver therefore fills its buffer from the top index down. Reading the store while it is empty raises an error flag. A data-port write that arrives before the control word has been programmed also raises an error flag.

Top module: `hashfe_top`

## Requirements
- R1: After reset, every readable register returns zero, `irq` is low, `core_rst` is low and `dig_ready` is high.
- R2: The message length is readable and writable, with the upper half at 0x04 and the lower half at 0x08. Together they drive `core_len`. The control word at 0x0C holds the algorithm in bits [1:0] and the byte order in bits [9:8], which drive `core_algo` and `core_order`. Each control write pulses `core_start` high for exactly one cycle.
- R3: The digest length in words is 4, 5, 7 or 8 for algorithm codes 0 (MD5), 1 (SHA-1), 2 (SHA-224) and 3 (SHA-256). Each read of 0x1C removes and returns one word, most recently pushed first.
- R4: Status register 0x10 behaves as follows:
  - Bit 0 sets when any digest word is accepted.
  - Bit 1 sets when the accepted count reaches the digest length of the selected algorithm, and not before.
- R5: Reading 0x1C while the store is empty returns zero and sets status bit 2.
- R6: A pulse on `data_wr` sets status bit 3 if the control word has not been written since the last reset; after it has been written, the pulse has no effect.
- R7: Writing a 1 to a bit of 0x18 clears that sticky status bit (bits 3:0). An event that sets a bit in the same cycle as its clear leaves it set.
- R8: Status bit 8 is high while the store holds any word. `irq` is the OR of (status AND enable at 0x14), delayed by one register stage. A disabled bit never raises `irq`.
- R9: Writing 1 to bit 0 of 0x00 raises `core_rst`, empties the store and zeroes status, enable, length and control. Other writes are ignored while it is held. Writing 0 releases it, and the data-port error then applies again.
- R10: Reads of unmapped offsets, and of the clear register 0x18, return zero and remove nothing from the store.
- R11: With the store at its depth of 8, `dig_ready` is low and a presented word is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| data_wr | input | 1 | Data-port word strobe from the packer |
| core_rst | output | 1 | Soft reset to the core |
| core_start | output | 1 | One-cycle pulse after a control write |
| core_algo | output | 2 | Algorithm code |
| core_order | output | 2 | Byte-order code |
| core_len | output | 64 | Message length in bits |
| dig_valid | input | 1 | Core presents a digest word |
| dig_word | input | 32 | Digest word |
| dig_ready | output | 1 | Store accepts a word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a digest push setting the same flag. Only that coincidence exposes a clear that wins over a set. The bench drives the bus clear and the stub's `dig_valid` from the same negative edge, so both reach the same rising edge.

A second hard case is the full store: a ninth word is held on the handshake while `dig_ready` is low. The bench then proves that nothing was accepted by popping and checking the top word. A table of all four algorithms walks the digest length boundary. It checks that bit 1 stays low one word short of the digest length and rises on the last word.

// File: rtl/hashfe_pkg.sv
package hashfe_pkg;
   localparam int OFS_SRST  = 'h00;
   localparam int OFS_LENH  = 'h04;
   localparam int OFS_LENL  = 'h08;
   localparam int OFS_CTRL  = 'h0C;
   localparam int OFS_ISTAT = 'h10;
   localparam int OFS_IEN   = 'h14;
   localparam int OFS_ICLR  = 'h18;
   localparam int OFS_RESQ  = 'h1C;

   localparam int EV_AVAIL = 0;
   localparam int EV_DONE  = 1;
   localparam int EV_RDERR = 2;
   localparam int EV_WRERR = 3;
   localparam int N_EV     = 4;
   localparam int STAT_W   = 9;

   typedef enum logic [1:0] {
      ALG_MD5    = 2'd0,
      ALG_SHA1   = 2'd1,
      ALG_SHA224 = 2'd2,
      ALG_SHA256 = 2'd3
   } alg_e;

   function automatic int unsigned digest_words(alg_e a);
      case (a)
         ALG_MD5:    return 4;
         ALG_SHA1:   return 5;
         ALG_SHA224: return 7;
         default:    return 8;
      endcase
   endfunction
endpackage

// File: rtl/hashfe_regs.sv
module hashfe_regs
   import hashfe_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic                soft_q,
   output logic [2*DATA_W-1:0] len_q,
   output alg_e                algo_q,
   output logic [1:0]          order_q,
   output logic                cfg_q,
   output logic                start_q,
   output logic                clr_wr,
   output logic                en_wr,
   output logic                pop_rd
);
   logic wr_s, rd_s;
   assign wr_s = bus_en & bus_we;
   assign rd_s = bus_en & ~bus_we;

   assign clr_wr = wr_s & ~soft_q & (bus_addr == ADDR_W'(OFS_ICLR));
   assign en_wr  = wr_s & ~soft_q & (bus_addr == ADDR_W'(OFS_IEN));
   assign pop_rd = rd_s & ~soft_q & (bus_addr == ADDR_W'(OFS_RESQ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q  <= 1'b0;
         len_q   <= '0;
         algo_q  <= ALG_MD5;
         order_q <= 2'd0;
         cfg_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (wr_s && bus_addr == ADDR_W'(OFS_SRST))
            soft_q <= bus_wdata[0];
         if (soft_q) begin
            len_q   <= '0;
            algo_q  <= ALG_MD5;
            order_q <= 2'd0;
            cfg_q   <= 1'b0;
         end else if (wr_s) begin
            if (bus_addr == ADDR_W'(OFS_LENH))
               len_q[2*DATA_W-1:DATA_W] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_LENL))
               len_q[DATA_W-1:0] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
               algo_q  <= alg_e'(bus_wdata[1:0]);
               order_q <= bus_wdata[9:8];
               cfg_q   <= 1'b1;
               start_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/hashfe_lifo.sv
module hashfe_lifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     top_data,
   output logic [CNT_W-1:0] cnt,
   output logic             full,
   output logic             empty
);
   logic [W-1:0] mem [DEPTH];
   logic         do_push, do_pop;
   logic [CNT_W-1:0] cnt_dn;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full & ~flush;
   assign do_pop  = pop & ~empty & ~flush;
   assign cnt_dn  = cnt - CNT_W'(1);
   assign top_data = mem[IDX_W'(cnt_dn)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (flush)   cnt <= '0;
      else if (do_push && !do_pop) cnt <= cnt + CNT_W'(1);
      else if (do_pop && !do_push) cnt <= cnt_dn;
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         if (do_pop) mem[IDX_W'(cnt_dn)] <= push_data;
         else        mem[IDX_W'(cnt)]    <= push_data;
      end
   end
endmodule

// File: rtl/hashfe_irq.sv
module hashfe_irq
   import hashfe_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [N_EV-1:0]   set_vec,
   input  logic              clr_wr,
   input  logic [N_EV-1:0]   clr_mask,
   input  logic              en_wr,
   input  logic [STAT_W-1:0] en_data,
   input  logic              level,
   output logic [STAT_W-1:0] stat,
   output logic [STAT_W-1:0] en_q,
   output logic              irq
);
   logic [N_EV-1:0] sticky_q;
   logic [N_EV-1:0] kill;
   logic            req;

   assign kill = clr_wr ? clr_mask : '0;
   assign stat = {level, {(STAT_W-1-N_EV){1'b0}}, sticky_q};
   assign req  = |(stat & en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         en_q     <= '0;
      end else if (flush) begin
         sticky_q <= '0;
         en_q     <= '0;
      end else begin
         sticky_q <= (sticky_q & ~kill) | set_vec;
         if (en_wr) en_q <= en_data;
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= req;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = req;
   end
endmodule

// File: rtl/hashfe_top.sv
module hashfe_top
   import hashfe_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 8,
   parameter bit IRQ_REG = 1'b1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                data_wr,
   output logic                core_rst,
   output logic                core_start,
   output logic [1:0]          core_algo,
   output logic [1:0]          core_order,
   output logic [2*DATA_W-1:0] core_len,
   input  logic                dig_valid,
   input  logic [DATA_W-1:0]   dig_word,
   output logic                dig_ready,
   output logic                irq
);
   if (DATA_W != 32) begin : g_bad_width
      $error("hashfe_top: register bus must be 32 bits");
   end
   if (DEPTH < 8) begin : g_bad_depth
      $error("hashfe_top: store must hold a full SHA-256 digest");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("hashfe_top: address too narrow for register map");
   end

   logic               soft_q, cfg_done, clr_wr, en_wr, pop_rd;
   alg_e               algo;
   logic [CNT_W-1:0]   cnt, cnt_up, need;
   logic               full, empty, push;
   logic [DATA_W-1:0]  top_word;
   logic [N_EV-1:0]    ev;
   logic [STAT_W-1:0]  stat, en_q;

   hashfe_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .soft_q(soft_q), .len_q(core_len), .algo_q(algo), .order_q(core_order),
      .cfg_q(cfg_done), .start_q(core_start),
      .clr_wr(clr_wr), .en_wr(en_wr), .pop_rd(pop_rd)
   );

   assign core_rst  = soft_q;
   assign core_algo = algo;
   assign dig_ready = ~full & ~soft_q;
   assign push      = dig_valid & dig_ready;

   hashfe_lifo #(.W(DATA_W), .DEPTH(DEPTH)) lifo_i (
      .clk(clk), .rst_n(rst_n), .flush(soft_q),
      .push(push), .push_data(dig_word), .pop(pop_rd),
      .top_data(top_word), .cnt(cnt), .full(full), .empty(empty)
   );

   assign need   = CNT_W'(digest_words(algo));
   assign cnt_up = cnt + CNT_W'(1);

   always_comb begin
      ev = '0;
      ev[EV_AVAIL] = push;
      ev[EV_DONE]  = push & ~pop_rd & (cnt_up == need);
      ev[EV_RDERR] = pop_rd & empty;
      ev[EV_WRERR] = data_wr & ~cfg_done & ~soft_q;
   end

   hashfe_irq #(.IRQ_REG(IRQ_REG)) irq_i (
      .clk(clk), .rst_n(rst_n), .flush(soft_q),
      .set_vec(ev), .clr_wr(clr_wr), .clr_mask(bus_wdata[N_EV-1:0]),
      .en_wr(en_wr), .en_data(bus_wdata[STAT_W-1:0]),
      .level(~empty), .stat(stat), .en_q(en_q), .irq(irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         case (bus_addr)
            ADDR_W'(OFS_SRST):  bus_rdata = {{(DATA_W-1){1'b0}}, soft_q};
            ADDR_W'(OFS_LENH):  bus_rdata = core_len[2*DATA_W-1:DATA_W];
            ADDR_W'(OFS_LENL):  bus_rdata = core_len[DATA_W-1:0];
            ADDR_W'(OFS_CTRL):  bus_rdata = {{(DATA_W-10){1'b0}}, core_order, 6'd0, core_algo};
            ADDR_W'(OFS_ISTAT): bus_rdata = {{(DATA_W-STAT_W){1'b0}}, stat};
            ADDR_W'(OFS_IEN):   bus_rdata = {{(DATA_W-STAT_W){1'b0}}, en_q};
            ADDR_W'(OFS_RESQ):  bus_rdata = (empty || soft_q) ? '0 : top_word;
            default:            bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/hashfe_chk.sv
module hashfe_chk #(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              soft_q,
   input logic              cfg_done,
   input logic              data_wr,
   input logic              core_start,
   input logic [CNT_W-1:0]  cnt,
   input logic              dig_ready,
   input logic [8:0]        stat,
   input logic [8:0]        en_q,
   input logic              irq
);
   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && !soft_q && bus_addr == ADDR_W'('h0C)) |=> core_start);

   p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && !soft_q && bus_addr == ADDR_W'('h1C) && cnt == '0) |=> stat[2]);

   p_early_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !cfg_done && !soft_q) |=> stat[3]);

   p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat & en_q)) |=> irq);

   p_soft_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_q |=> (cnt == '0));

   p_full_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(DEPTH)) |-> !dig_ready);
endmodule

bind hashfe_top hashfe_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
   .bus_addr(bus_addr), .soft_q(soft_q), .cfg_done(cfg_done),
   .data_wr(data_wr), .core_start(core_start), .cnt(cnt),
   .dig_ready(dig_ready), .stat(stat), .en_q(en_q), .irq(irq)
);

// File: tb/hashfe_top_tb_top.sv
module hashfe_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        data_wr = 1'b0;
   logic        core_rst, core_start;
   logic [1:0]  core_algo, core_order;
   logic [63:0] core_len;
   logic        dig_valid = 1'b0;
   logic [31:0] dig_word = '0;
   logic        dig_ready, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hashfe_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .data_wr(data_wr), .core_rst(core_rst), .core_start(core_start),
      .core_algo(core_algo), .core_order(core_order), .core_len(core_len),
      .dig_valid(dig_valid), .dig_word(dig_word), .dig_ready(dig_ready),
      .irq(irq)
   );

   // {algorithm code, seed of first digest word}
   localparam logic [33:0] VEC [4] = '{
      {2'd0, 32'h1111_0000},
      {2'd1, 32'hA5A5_0100},
      {2'd2, 32'h0BAD_0200},
      {2'd3, 32'hC0DE_0300}
   };

   function automatic int nwords(logic [1:0] a);
      case (a)
         2'd0: return 4;
         2'd1: return 5;
         2'd2: return 7;
         default: return 8;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic push(input logic [31:0] w);
      dig_valid = 1'b1; dig_word = w;
      @(negedge clk);
      dig_valid = 1'b0;
   endtask

   task automatic dpulse();
      data_wr = 1'b1;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h10, v); chk("R1 status", v, 0);
      rd(8'h0C, v); chk("R1 control", v, 0);
      rd(8'h04, v); chk("R1 len hi", v, 0);
      chk("R1 irq/rst/ready", {irq, core_rst, dig_ready}, 3'b001);

      // R6 data before configuration
      dpulse();
      rd(8'h10, v); chk("R6 early data flag", v, 32'h8);

      // R2 configuration
      wr(8'h04, 32'h0000_0001);
      wr(8'h08, 32'h0000_0200);
      chk("R2 core_len", core_len, 64'h1_0000_0200);
      rd(8'h08, v); chk("R2 len lo readback", v, 32'h200);
      wr(8'h0C, 32'h0000_0203);
      chk("R2 start pulse", core_start, 1);
      chk("R2 algo/order", {core_algo, core_order}, 4'b1110);
      @(negedge clk);
      chk("R2 start one cycle", core_start, 0);
      rd(8'h0C, v); chk("R2 control readback", v, 32'h203);

      // R7 clear, R6 no error once configured
      wr(8'h18, 32'hF);
      dpulse();
      rd(8'h10, v); chk("R6 configured data ok", v, 0);

      // table walk: R3 R4 R5 R8
      for (int i = 0; i < 4; i++) begin
         logic [1:0]  a;
         logic [31:0] seed;
         int n;
         a = VEC[i][33:32];
         seed = VEC[i][31:0];
         n = nwords(a);
         wr(8'h0C, {30'd0, a});
         wr(8'h14, 32'h2);
         for (int k = 0; k < n - 1; k++) push(seed + k);
         rd(8'h10, v); chk("R4 not done one short", v, 32'h101);
         chk("R8 masked irq low", irq, 0);
         push(seed + n - 1);
         rd(8'h10, v); chk("R4 done at digest length", v, 32'h103);
         @(negedge clk);
         chk("R8 irq raised", irq, 1);
         for (int k = n - 1; k >= 0; k--) begin
            rd(8'h1C, v); chk("R3 pop order", v, seed + k);
         end
         wr(8'h18, 32'h2);
         rd(8'h1C, v); chk("R5 empty read zero", v, 0);
         rd(8'h10, v); chk("R5 read error flag", v, 32'h5);
         @(negedge clk);
         chk("R8 disabled bits keep irq low", irq, 0);
         wr(8'h18, 32'hF);
         rd(8'h10, v); chk("R7 all cleared", v, 0);
      end

      // R7 set wins over clear in the same cycle
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h1;
      dig_valid = 1'b1; dig_word = 32'hFACE_0001;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; dig_valid = 1'b0;
      rd(8'h10, v); chk("R7 set wins", v, 32'h101);
      wr(8'h18, 32'h1);
      rd(8'h10, v); chk("R7 clear alone, R8 level", v, 32'h100);
      rd(8'h1C, v); chk("R3 single pop", v, 32'hFACE_0001);
      rd(8'h10, v); chk("R8 level drops", v, 0);

      // R11 full store, R10 unmapped reads
      for (int k = 0; k < 8; k++) push(32'hD000_0000 + k);
      chk("R11 ready low when full", dig_ready, 0);
      push(32'hDEAD_BEEF);
      rd(8'h24, v); chk("R10 unmapped zero", v, 0);
      rd(8'h18, v); chk("R10 clear reg reads zero", v, 0);
      rd(8'h1C, v); chk("R11 R10 top intact", v, 32'hD000_0007);
      chk("R11 ready after pop", dig_ready, 1);

      // R9 soft reset
      wr(8'h00, 32'h1);
      chk("R9 core_rst high", {core_rst, dig_ready}, 2'b10);
      wr(8'h08, 32'h55);
      wr(8'h00, 32'h0);
      rd(8'h00, v); chk("R9 released", v, 0);
      rd(8'h08, v); chk("R9 len cleared, write ignored", v, 0);
      rd(8'h0C, v); chk("R9 control cleared", v, 0);
      rd(8'h10, v); chk("R9 status and store cleared", v, 0);
      chk("R9 ready again", dig_ready, 1);
      dpulse();
      rd(8'h10, v); chk("R9 R6 unconfigured again", v, 32'h8);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule